// File: doc/BRIEF.md
# Two-Wire Slave Front End with Persistent Command Pointer

This block is the serial front end of a register-mapped peripheral on a two-wire, I2C-compatible bus. A system clock much faster than the bus oversamples SCL and SDA through a two-flop synchroniser. Edges of the synchronised copies reveal START and STOP conditions and bit clocks. The slave recognises a 7-bit address made of the fixed prefix `100` and four strap bits. It acknowledges matching traffic by pulling SDA low, and it models open-drain SDA as a drive-low enable.

The first byte of a write is a command byte that loads an 8-bit register pointer. Each later data byte produces a one-cycle write strobe to the pointed register, and the pointer then advances. The pointer persists between transactions. A read starts from the stored pointer: the block pulses a read request, captures the register value in that same cycle and shifts it out MSB first. The pointer advances after each byte sent. A master NACK ends the read.

The control is a single state machine. Its states are IDLE, ADDR (receive address), ADDR_ACK, CMD (receive command), CMD_ACK, WDATA (receive data), WDATA_ACK, RDATA (send data), RACK (sample master acknowledge) and IGNORE.
- STOP moves any state to IDLE, and START moves any state to ADDR.
- When the eighth address bit's clock falls, ADDR goes to ADDR_ACK on a match or to IGNORE otherwise.
- When the ninth clock falls, ADDR_ACK goes to CMD for a write or to RDATA for a read.
- CMD goes to CMD_ACK and then to WDATA. WDATA goes to WDATA_ACK and then back to WDATA.
- After the eighth falling edge, RDATA goes to RACK. RACK goes to RDATA on an ACK or to IGNORE on a NACK.

Top module: `twi_cmd_slave`

## Requirements
- R1: A START (synchronised SDA falls while synchronised SCL stays high) starts address reception. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released. After reset, and after every STOP, the slave drives nothing.
- R2: The address byte is received MSB first: 7 address bits, then the R/W bit (0 = write, 1 = read). The slave matches when the address equals {3'b100, addr_sel_i}; it then drives SDA low for the whole ninth clock. On a mismatch it never drives SDA and ignores traffic until the next START or STOP.
- R3: In a write, the first byte after the address loads the pointer and is acknowledged. If STOP follows it, no write strobe occurs.
- R4: Each later data byte in a write gives one `wr_stb_o` pulse, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte (MSB first on the bus). The byte is acknowledged, and the pointer then increments by one.
- R5: The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R6: A read loads `rd_data_i` in the cycle `rd_req_o` pulses, with `rd_addr_o` equal to the pointer. The slave then shifts the byte out MSB first, driving SDA low for each 0 bit. Its drive changes only while SCL is low.
- R7: After a read byte the slave releases SDA for the ninth clock. An ACK (SDA low) loads the next byte from the incremented pointer. A NACK ends the read with no further request and no further pointer step, so the next read starts one past the last byte sent.
- R8: The pointer persists across transactions: a read without a preceding command byte starts at the stored pointer.
- R9: A repeated START restarts address reception from any state, including after a mismatch and in the middle of a write.
- R10: `wr_stb_o` and `rd_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| addr_sel_i | input | 4 | Low four bits of the slave address |
| sda_drive_o | output | 1 | 1 = pull SDA low, 0 = release |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address for the write |
| wr_data_o | output | 8 | Register data for the write |
| rd_req_o | output | 1 | One-cycle read request; data is captured this cycle |
| rd_addr_o | output | 8 | Register address to read (current pointer) |
| rd_data_i | input | 8 | Register value for `rd_addr_o`, valid combinationally |

## Verification
The write strobe and the pointer increment happen in the same system cycle. The strobe must therefore carry the value the pointer had before the step, while the following byte sees the stepped value. A burst write that starts at 0xFE provokes this at the wrap: the logged strobe addresses must read 0xFE, 0xFF, 0x00. A two-byte read followed by a fresh one-byte read judges the request/increment pairing on the read side: the second read must start one past the last byte sent, not two.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    localparam logic [BYTE_W-SEL_W-2:0] ADDR_PREFIX = 3'b100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // [STAGES-1] is the synchronised level, [STAGES] the previous one
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[STAGES-1];
    assign scl_old = scl_pipe[STAGES];
    assign sda_now = sda_pipe[STAGES-1];
    assign sda_old = sda_pipe[STAGES];

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic [W-1:0] ptr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr_o <= '0;
        else if (load_i)  ptr_o <= load_val_i;
        else if (step_i)  ptr_o <= ptr_o + W'(1);
    end
endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
    import twi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  addr_sel_i,
    output logic              sda_drive_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic [BYTE_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    twi_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              rw_q;
    logic              mack_q;
    logic [BYTE_W-1:0] ptr_q;

    logic byte_done, addr_hit, ptr_load, ptr_step, rd_load;

    assign byte_done = scl_fall && (cnt_q == CNT_FULL);
    assign addr_hit  = (shreg_q[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel_i});
    assign ptr_load  = (state_q == ST_CMD) && byte_done;
    assign ptr_step  = ((state_q == ST_WDATA) && byte_done) ||
                       ((state_q == ST_RDATA) && scl_fall && (cnt_q == CNT_LAST));
    assign rd_load   = ((state_q == ST_ADDR_ACK) && scl_fall && rw_q) ||
                       ((state_q == ST_RACK) && scl_fall && mack_q);

    twi_ptr #(.W(BYTE_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (shreg_q),
        .step_i     (ptr_step),
        .ptr_o      (ptr_q)
    );

    // State register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_det) begin
                cnt_q <= '0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise && cnt_q != CNT_FULL) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end
                        if (state_q == ST_ADDR && byte_done)
                            rw_q <= shreg_q[0];
                    end
                    ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                        cnt_q <= '0;
                        if (rd_load) shreg_q <= rd_data_i;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_RACK: begin
                        cnt_q <= '0;
                        if (scl_rise) mack_q <= ~sda_s;
                        if (rd_load)  shreg_q <= rd_data_i;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && cnt_q == CNT_LAST) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_drive_o = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK) ||
                      (state_q == ST_WDATA_ACK) ||
                      ((state_q == ST_RDATA) && !shreg_q[BYTE_W-1]);
        wr_stb_o    = (state_q == ST_WDATA) && byte_done;
        wr_addr_o   = ptr_q;
        wr_data_o   = shreg_q;
        rd_req_o    = rd_load;
        rd_addr_o   = ptr_q;
    end
endmodule

// File: rtl/twi_cmd_slave_chk.sv
module twi_cmd_slave_chk
    import twi_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input twi_state_e   state,
    input logic         start_det,
    input logic         stop_det,
    input logic         wr_stb,
    input logic         rd_req,
    input logic         sda_drive,
    input logic [W-1:0] ptr
);
    // R10
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_req));

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R9
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (ptr == W'($past(ptr) + W'(1))));

    // R2
    drive_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive |-> (state inside {ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK, ST_RDATA}));

    // R7
    rd_req_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (state inside {ST_ADDR_ACK, ST_RACK}));
endmodule

bind twi_cmd_slave twi_cmd_slave_chk #(.W(twi_pkg::BYTE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_stb    (wr_stb_o),
    .rd_req    (rd_req_o),
    .sda_drive (sda_drive_o),
    .ptr       (ptr_q)
);

// File: tb/twi_cmd_slave_test.sv
module twi_cmd_slave_test;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h8A;
    localparam logic [7:0] AR = 8'h8B;

    // {address byte, command, data, expected address ack}
    localparam logic [24:0] VEC [4] = '{
        {8'h8A, 8'h10, 8'hA5, 1'b1},
        {8'h86, 8'h11, 8'h22, 1'b0},
        {8'h8A, 8'hFF, 8'h3C, 1'b1},
        {8'h2A, 8'h33, 8'h44, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_drive_o, wr_stb_o, rd_req_o;
    logic [7:0] wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;

    int checks = 0, fails = 0, wn = 0, rn = 0, overlap = 0, drv_bad = 0;
    logic [7:0] wa [64];
    logic [7:0] wd [64];
    logic [7:0] ra_last = '0;
    logic drv_prev = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hC3;
    endfunction

    assign sda_line  = sda_m & ~sda_drive_o;
    assign rd_data_i = mem_val(rd_addr_o);

    twi_cmd_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(4'b0101), .sda_drive_o(sda_drive_o),
        .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_stb_o && wn < 64) begin
                wa[wn] = wr_addr_o;
                wd[wn] = wr_data_o;
                wn++;
            end
            if (rd_req_o) begin
                ra_last = rd_addr_o;
                rn++;
            end
            if (wr_stb_o && rd_req_o) overlap++;
            if (sda_drive_o != drv_prev && scl_m) drv_bad++;
            drv_prev = sda_drive_o;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q(); scl_m = 1'b1; q();
        ack = ~sda_line;
        q(); scl_m = 1'b0; q();
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            q(); scl_m = 1'b1; q();
            d = {d[6:0], sda_line};
            q(); scl_m = 1'b0; q();
        end
        sda_m = ack ? 1'b0 : 1'b1;
        q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a, a2, a3;
        logic [7:0] d;
        int w0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 reset drive", sda_drive_o, 0);
        chk("R1 reset wr_stb", wr_stb_o, 0);
        chk("R1 reset rd_req", rd_req_o, 0);

        // Vector table: single-byte writes with matching and non-matching addresses
        for (int v = 0; v < 4; v++) begin
            w0 = wn;
            bus_start();
            write_byte(VEC[v][24:17], a);
            chk("R2 address ack", a, VEC[v][0]);
            write_byte(VEC[v][16:9], a2);
            write_byte(VEC[v][8:1], a3);
            bus_stop();
            chk("R1 released after stop", sda_drive_o, 0);
            if (VEC[v][0]) begin
                chk("R4 data ack", a3, 1);
                chk("R4 one strobe", wn - w0, 1);
                chk("R4 strobe addr", wa[w0], VEC[v][16:9]);
                chk("R4 strobe data", wd[w0], VEC[v][8:1]);
            end else begin
                chk("R2 ignored data ack", a3, 0);
                chk("R2 no strobe", wn - w0, 0);
            end
        end

        // R4 R5 burst across the wrap
        w0 = wn;
        bus_start();
        write_byte(AW, a); write_byte(8'hFE, a);
        write_byte(8'h11, a); write_byte(8'h22, a); write_byte(8'h33, a);
        bus_stop();
        chk("R4 burst count", wn - w0, 3);
        chk("R4 burst addr0", wa[w0], 8'hFE);
        chk("R5 burst addr1", wa[w0+1], 8'hFF);
        chk("R5 wrap addr2", wa[w0+2], 8'h00);
        chk("R4 burst data2", wd[w0+2], 8'h33);

        // R3 command-only write
        w0 = wn;
        bus_start();
        write_byte(AW, a); write_byte(8'h40, a2);
        bus_stop();
        chk("R3 cmd ack", a2, 1);
        chk("R3 no strobe", wn - w0, 0);

        // R6 R8 read from stored pointer, ACK then NACK
        r0 = rn;
        bus_start();
        write_byte(AR, a);
        chk("R2 read addr ack", a, 1);
        read_byte(1'b1, d);
        chk("R8 read byte0", d, mem_val(8'h40));
        read_byte(1'b0, d);
        chk("R6 read byte1", d, mem_val(8'h41));
        bus_stop();
        chk("R7 two requests", rn - r0, 2);
        chk("R7 last request addr", ra_last, 8'h41);

        // R7 NACK left pointer one past last byte sent
        bus_start();
        write_byte(AR, a); read_byte(1'b0, d);
        bus_stop();
        chk("R7 next read start", d, mem_val(8'h42));

        // R9 repeated start from write to read
        bus_start();
        write_byte(AW, a); write_byte(8'h20, a);
        bus_start();
        write_byte(AR, a); read_byte(1'b0, d);
        bus_stop();
        chk("R9 restart read", d, mem_val(8'h20));

        // R9 R2 repeated start after mismatch
        w0 = wn;
        bus_start();
        write_byte(8'h86, a);
        chk("R2 mismatch nack", a, 0);
        bus_start();
        write_byte(AW, a); write_byte(8'h30, a); write_byte(8'h77, a);
        bus_stop();
        chk("R9 strobe after restart", wn - w0, 1);
        chk("R9 strobe addr", wa[w0], 8'h30);
        chk("R9 strobe data", wd[w0], 8'h77);

        chk("R10 no overlap", overlap, 0);
        chk("R6 drive changes only while SCL low", drv_bad, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule